// File: doc/BRIEF.md
# Interrupt and Reset Sequencing Unit

This unit sits beside an instruction-executing core and decides when the core must leave its normal flow. It handles two hardware interrupt sources. The first is a non-maskable request that fires on a rising edge. The second is a maskable request that is sensed by level and gated by an interrupt-enable flag. A decision is made only when the core signals an instruction boundary. When the unit responds it reports the interrupt type and the vector-table address for that type, and it clears the enable flag. For a maskable request the type is not known in advance, so the unit first asks for an acknowledge cycle and then takes the type byte that the cycle returns.

The unit also sequences reset. The raw reset input is synchronized, and the core is held dormant while reset is active. A short reset is stretched to a minimum length. After reset ends, a fixed initialization interval runs, and then a one-cycle start pulse carries the restart address. Non-maskable edges that arrive during reset, during initialization or in the first cycles after start are discarded.

Top module: `intr_reset_seq`

## Requirements
- R1: After the first rising clock edge at which `rst_in` is sampled low following a reset of at least RST_MIN_CYC cycles, `core_hold` stays high for INIT_CYC+2 further edges. On the edge after that (edge INIT_CYC+3 in total), `core_hold` falls and `boot_go` pulses high for exactly one cycle, with `tgt_addr` equal to RESTART_ADDR (default 0xFFFF0).
- R2: A reset pulse shorter than RST_MIN_CYC cycles is stretched. `core_hold` is then high for exactly RST_MIN_CYC+INIT_CYC consecutive cycles.
- R3: While `core_hold` is high, `int_take` and `vec_valid` stay low whatever `instr_end`, `intr_in` and `nmi_in` do. Writes to the flag through `if_wr` while `rst_in` is high have no effect, and `if_flag` reads 0 when reset ends.
- R4: A rising edge on `nmi_in` is latched. At the next `instr_end`, one cycle later, the unit raises `int_take`, `int_nmi` and `vec_valid` together, with `vec_type` = NMI_TYPE (default 2) and `tgt_addr` = NMI_TYPE×4. The latch is cleared by that service.
- R5: When a latched non-maskable edge and an enabled maskable request meet at the same boundary, the non-maskable one is served first, and `ack_req` stays low.
- R6: A level held high on `nmi_in` is served once. A new rising edge that is recognized in the same cycle as a service, or later, is latched again and served at a following boundary.
- R7: Rising edges of `nmi_in` that are recognized while `core_hold` is high, or during the first NMI_BLANK cycles after `boot_go`, are dropped. This includes a level that is held high across the end of reset.
- R8: A maskable request is taken at a boundary only if `intr_in` was high at the clock edge before the boundary edge and `if_flag` is 1. It produces `int_take` and `ack_req` with `int_nmi` low. A request that is high only in the boundary cycle, or any request while `if_flag` is 0, is not taken.
- R9: After `ack_req`, the first cycle with `ack_valid` high produces, one cycle later, `vec_valid` with `vec_type` = `ack_type` and `tgt_addr` = `ack_type`×4. Boundaries that occur while the acknowledge is outstanding start no service.
- R10: Every service clears `if_flag`, and a flag write in the same cycle as a service loses to the service. Otherwise `if_wr` loads `if_wdata` into `if_flag`.
- R11: Every vector address lies in 0..0x3FF, with bits [1:0] zero and bits [9:2] equal to the type (type 0xFF gives 0x3FC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw reset request, active high, asynchronous |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive, asynchronous |
| intr_in | input | 1 | Maskable request, level sensitive, synchronous |
| instr_end | input | 1 | Instruction boundary strobe from the core |
| if_wr | input | 1 | Load strobe for the interrupt-enable flag |
| if_wdata | input | 1 | Value loaded into the flag |
| ack_valid | input | 1 | Acknowledge cycle has returned a type byte |
| ack_type | input | TYPE_W | Type byte from the acknowledge cycle |
| core_hold | output | 1 | Core must stay dormant |
| boot_go | output | 1 | One-cycle start pulse after initialization |
| int_take | output | 1 | An interrupt service starts this cycle |
| int_nmi | output | 1 | The service being started is non-maskable |
| ack_req | output | 1 | Run an acknowledge cycle to fetch the type byte |
| vec_valid | output | 1 | `vec_type` and `tgt_addr` hold a vector |
| vec_type | output | TYPE_W | Interrupt type number |
| tgt_addr | output | ADDR_W | Vector-table address, or restart address with `boot_go` |
| if_flag | output | 1 | Current interrupt-enable flag |

## Verification
The bench uses the default parameters: a 20-bit address, an 8-bit type, two synchronizer stages, a minimum reset of 5 cycles, 7 initialization cycles and a 2-cycle blanking window. With these values the exact restart timing and the 12-cycle stretched hold can be counted edge by edge. An 8-bit type lets the top vector slot 0x3FC be reached through a single acknowledge. Because the synchronizer is short, a re-armed edge can be placed so that it is recognized on the very edge that serves the previous one. A seeded random phase then mixes maskable levels, flag writes, boundaries and acknowledges against a cycle model of the enable flag and the acknowledge handshake.

// File: rtl/irs_pkg.sv
package irs_pkg;

  typedef enum logic [1:0] {
    RS_RESET = 2'd0,
    RS_INIT  = 2'd1,
    RS_RUN   = 2'd2
  } rst_state_e;

  typedef enum logic {
    AR_IDLE = 1'b0,
    AR_WAIT = 1'b1
  } arb_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irs_sync.sv
module irs_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          ASYNC_SET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (ASYNC_SET) begin : g_async_set
      // reset synchronizer: assert at once, release through the chain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/irs_reset_fsm.sv
module irs_reset_fsm
  import irs_pkg::*;
#(
  parameter int unsigned RST_MIN_CYC = 5,
  parameter int unsigned INIT_CYC    = 7,
  parameter int unsigned NMI_BLANK   = 2
) (
  input  logic clk,
  input  logic rst_sync,
  output logic core_hold,
  output logic boot_go,
  output logic boot_now,
  output logic nmi_ok
);

  localparam int unsigned CNT_MAX = max2(RST_MIN_CYC, INIT_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned BLK_W   = max2($clog2(NMI_BLANK + 1), 1);
  localparam logic [CNT_W-1:0] MIN_C     = CNT_W'(RST_MIN_CYC);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [BLK_W-1:0] BLANK_C   = BLK_W'(NMI_BLANK);

  rst_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blank;

  // start condition, one cycle ahead of the registered pulse
  assign boot_now = !rst_sync && (st == RS_INIT) && (cnt == INIT_LAST);

  always_ff @(posedge clk) begin
    if (rst_sync) begin
      st        <= RS_RESET;
      core_hold <= 1'b1;
      boot_go   <= 1'b0;
      blank     <= '0;
      if (st != RS_RESET)  cnt <= CNT_W'(1);
      else if (cnt < MIN_C) cnt <= cnt + 1'b1;
    end else begin
      boot_go <= 1'b0;
      case (st)
        RS_RESET: begin
          // stretch short pulses up to the minimum width
          if (cnt >= MIN_C) begin
            st  <= RS_INIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_INIT: begin
          if (boot_now) begin
            st        <= RS_RUN;
            core_hold <= 1'b0;
            boot_go   <= 1'b1;
            blank     <= BLANK_C;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_RUN: begin
          if (blank != '0) blank <= blank - 1'b1;
        end
        default: begin
          st        <= RS_RESET;
          core_hold <= 1'b1;
          cnt       <= '0;
        end
      endcase
    end
  end

  assign nmi_ok = !core_hold && (blank == '0);

endmodule

// File: rtl/irs_nmi_latch.sv
module irs_nmi_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic accept,
  input  logic clear,
  output logic pend
);

  logic nmi_s;
  logic nmi_prev;
  logic rise;

  irs_sync #(
    .STAGES   (SYNC_STAGES),
    .ASYNC_SET(1'b0)
  ) u_nmi_sync (
    .clk(clk),
    .rst(rst),
    .d  (nmi_in),
    .q  (nmi_s)
  );

  assign rise = nmi_s & ~nmi_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      nmi_prev <= nmi_s;
      // a fresh edge beats the clear, so service re-arms at once
      if (rise && accept) pend <= 1'b1;
      else if (clear)     pend <= 1'b0;
    end
  end

endmodule

// File: rtl/irs_arbiter.sv
module irs_arbiter
  import irs_pkg::*;
#(
  parameter int unsigned        ADDR_W       = 20,
  parameter int unsigned        TYPE_W       = 8,
  parameter int unsigned        NMI_TYPE     = 2,
  parameter logic [ADDR_W-1:0]  RESTART_ADDR = 'hFFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              boot_now,
  input  logic              instr_end,
  input  logic              intr_in,
  input  logic              if_wr,
  input  logic              if_wdata,
  input  logic              ack_valid,
  input  logic [TYPE_W-1:0] ack_type,
  input  logic              nmi_pend,
  output logic              take_nmi,
  output logic              int_take,
  output logic              int_nmi,
  output logic              ack_req,
  output logic              vec_valid,
  output logic [TYPE_W-1:0] vec_type,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              if_flag
);

  localparam int unsigned       PAD_W = ADDR_W - TYPE_W - 2;
  localparam logic [TYPE_W-1:0] NMI_T = TYPE_W'(NMI_TYPE);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [TYPE_W-1:0] t);
    return {{PAD_W{1'b0}}, t, 2'b00};
  endfunction

  arb_state_e st;
  logic       intr_q;
  logic       at_bnd;
  logic       take_int;

  assign at_bnd   = instr_end && !hold && (st == AR_IDLE);
  assign take_nmi = at_bnd && nmi_pend;
  assign take_int = at_bnd && !nmi_pend && intr_q && if_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= AR_IDLE;
      intr_q    <= 1'b0;
      if_flag   <= 1'b0;
      int_take  <= 1'b0;
      int_nmi   <= 1'b0;
      ack_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_type  <= '0;
      tgt_addr  <= '0;
    end else begin
      intr_q    <= intr_in;
      int_take  <= take_nmi | take_int;
      int_nmi   <= take_nmi;
      ack_req   <= take_int;
      vec_valid <= 1'b0;

      if (take_nmi || take_int) if_flag <= 1'b0;
      else if (if_wr)           if_flag <= if_wdata;

      if (boot_now) tgt_addr <= RESTART_ADDR;

      if (take_nmi) begin
        vec_valid <= 1'b1;
        vec_type  <= NMI_T;
        tgt_addr  <= slot_addr(NMI_T);
      end

      if (take_int) st <= AR_WAIT;

      if (st == AR_WAIT && ack_valid) begin
        st        <= AR_IDLE;
        vec_valid <= 1'b1;
        vec_type  <= ack_type;
        tgt_addr  <= slot_addr(ack_type);
      end
    end
  end

endmodule

// File: rtl/intr_reset_seq.sv
module intr_reset_seq #(
  parameter int unsigned       ADDR_W       = 20,
  parameter int unsigned       TYPE_W       = 8,
  parameter int unsigned       SYNC_STAGES  = 2,
  parameter int unsigned       RST_MIN_CYC  = 5,
  parameter int unsigned       INIT_CYC     = 7,
  parameter int unsigned       NMI_BLANK    = 2,
  parameter int unsigned       NMI_TYPE     = 2,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'hFFFF0
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              nmi_in,
  input  logic              intr_in,
  input  logic              instr_end,
  input  logic              if_wr,
  input  logic              if_wdata,
  input  logic              ack_valid,
  input  logic [TYPE_W-1:0] ack_type,
  output logic              core_hold,
  output logic              boot_go,
  output logic              int_take,
  output logic              int_nmi,
  output logic              ack_req,
  output logic              vec_valid,
  output logic [TYPE_W-1:0] vec_type,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              if_flag
);

  logic rst_sync;
  logic boot_now;
  logic nmi_ok;
  logic nmi_pend;
  logic take_nmi;

  irs_sync #(
    .STAGES   (SYNC_STAGES),
    .ASYNC_SET(1'b1)
  ) u_rst_sync (
    .clk(clk),
    .rst(rst_in),
    .d  (1'b0),
    .q  (rst_sync)
  );

  irs_reset_fsm #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .INIT_CYC   (INIT_CYC),
    .NMI_BLANK  (NMI_BLANK)
  ) u_fsm (
    .clk      (clk),
    .rst_sync (rst_sync),
    .core_hold(core_hold),
    .boot_go  (boot_go),
    .boot_now (boot_now),
    .nmi_ok   (nmi_ok)
  );

  irs_nmi_latch #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_nmi (
    .clk   (clk),
    .rst   (rst_sync),
    .nmi_in(nmi_in),
    .accept(nmi_ok),
    .clear (take_nmi),
    .pend  (nmi_pend)
  );

  irs_arbiter #(
    .ADDR_W      (ADDR_W),
    .TYPE_W      (TYPE_W),
    .NMI_TYPE    (NMI_TYPE),
    .RESTART_ADDR(RESTART_ADDR)
  ) u_arb (
    .clk      (clk),
    .rst      (rst_sync),
    .hold     (core_hold),
    .boot_now (boot_now),
    .instr_end(instr_end),
    .intr_in  (intr_in),
    .if_wr    (if_wr),
    .if_wdata (if_wdata),
    .ack_valid(ack_valid),
    .ack_type (ack_type),
    .nmi_pend (nmi_pend),
    .take_nmi (take_nmi),
    .int_take (int_take),
    .int_nmi  (int_nmi),
    .ack_req  (ack_req),
    .vec_valid(vec_valid),
    .vec_type (vec_type),
    .tgt_addr (tgt_addr),
    .if_flag  (if_flag)
  );

endmodule

// File: rtl/irs_chk.sv
module irs_chk #(
  parameter int unsigned       ADDR_W       = 20,
  parameter int unsigned       TYPE_W       = 8,
  parameter int unsigned       NMI_TYPE     = 2,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'hFFFF0
) (
  input logic              clk,
  input logic              rst_in,
  input logic              core_hold,
  input logic              boot_go,
  input logic              int_take,
  input logic              int_nmi,
  input logic              ack_req,
  input logic              vec_valid,
  input logic [TYPE_W-1:0] vec_type,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              if_flag
);

  // R1
  boot_addr_chk: assert property (@(posedge clk) disable iff (rst_in)
    boot_go |-> (tgt_addr == RESTART_ADDR) && !core_hold);

  // R1
  boot_after_hold_chk: assert property (@(posedge clk) disable iff (rst_in)
    boot_go |-> $past(core_hold));

  // R3
  no_take_in_hold_chk: assert property (@(posedge clk) disable iff (rst_in)
    core_hold |-> !int_take && !vec_valid);

  // R4
  nmi_vec_chk: assert property (@(posedge clk) disable iff (rst_in)
    (int_take && int_nmi) |-> vec_valid && (vec_type == TYPE_W'(NMI_TYPE))
                              && (tgt_addr == ADDR_W'(NMI_TYPE * 4)));

  // R8
  ack_pair_chk: assert property (@(posedge clk) disable iff (rst_in)
    ack_req |-> int_take && !int_nmi);

  // R10
  if_clear_chk: assert property (@(posedge clk) disable iff (rst_in)
    int_take |-> !if_flag);

  // R11
  vec_range_chk: assert property (@(posedge clk) disable iff (rst_in)
    vec_valid |-> ((tgt_addr >> (TYPE_W + 2)) == '0)
                  && (tgt_addr[TYPE_W+1:2] == vec_type));

  // R1
  boot_excl_chk: assert property (@(posedge clk) disable iff (rst_in)
    $onehot0({boot_go, int_take}));

endmodule

bind intr_reset_seq irs_chk #(
  .ADDR_W      (ADDR_W),
  .TYPE_W      (TYPE_W),
  .NMI_TYPE    (NMI_TYPE),
  .RESTART_ADDR(RESTART_ADDR)
) u_irs_chk (
  .clk      (clk),
  .rst_in   (rst_in),
  .core_hold(core_hold),
  .boot_go  (boot_go),
  .int_take (int_take),
  .int_nmi  (int_nmi),
  .ack_req  (ack_req),
  .vec_valid(vec_valid),
  .vec_type (vec_type),
  .tgt_addr (tgt_addr),
  .if_flag  (if_flag)
);

// File: tb/intr_reset_seq_bench.sv
`timescale 1ns/1ps
module intr_reset_seq_bench;

  logic        clk = 1'b0;
  logic        rst_in, nmi_in, intr_in, instr_end, if_wr, if_wdata, ack_valid;
  logic [7:0]  ack_type;
  logic        core_hold, boot_go, int_take, int_nmi, ack_req, vec_valid, if_flag;
  logic [7:0]  vec_type;
  logic [19:0] tgt_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intr_reset_seq u_intr_reset_seq (
    .clk(clk), .rst_in(rst_in), .nmi_in(nmi_in), .intr_in(intr_in),
    .instr_end(instr_end), .if_wr(if_wr), .if_wdata(if_wdata),
    .ack_valid(ack_valid), .ack_type(ack_type),
    .core_hold(core_hold), .boot_go(boot_go), .int_take(int_take),
    .int_nmi(int_nmi), .ack_req(ack_req), .vec_valid(vec_valid),
    .vec_type(vec_type), .tgt_addr(tgt_addr), .if_flag(if_flag)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input logic [7:0] t);
    return {22'd0, t, 2'b00};
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic boundary();
    instr_end = 1'b1;
    step();
    instr_end = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int takes;
    int held;
    logic m_if, m_iq, m_wait;
    logic ii, ie, iw, wd, av;
    logic [7:0] at;
    logic [31:0] exp_v, act_v;

    rst_in = 1; nmi_in = 0; intr_in = 0; instr_end = 0;
    if_wr = 0; if_wdata = 0; ack_valid = 0; ack_type = 0;

    // reset with writes and boundaries pushed in
    if_wr = 1; if_wdata = 1; intr_in = 1; instr_end = 1;
    repeat (8) step();
    check("R3 hold during reset", {31'd0, core_hold}, 1);
    check("R3 no take in reset", {31'd0, int_take}, 0);
    check("R3 flag write ignored in reset", {31'd0, if_flag}, 0);
    rst_in = 0; if_wr = 0; if_wdata = 0;
    takes = 0;
    for (int i = 0; i < 9; i++) begin
      step();
      takes += int'(int_take);
    end
    check("R3 no take during init", takes, 0);
    check("R1 still held before start", {30'd0, core_hold, boot_go}, 32'h2);
    step();
    check("R1 start pulse", {30'd0, core_hold, boot_go}, 32'h1);
    check("R1 restart address", tgt_addr, 32'hFFFF0);
    check("R3 flag zero after reset", {31'd0, if_flag}, 0);
    instr_end = 0; intr_in = 0;
    step();
    check("R1 start pulse one cycle", {31'd0, boot_go}, 0);
    repeat (4) step();

    // R4 single edge
    nmi_in = 1;
    repeat (3) step();
    boundary();
    check("R4 nmi take", {29'd0, int_take, int_nmi, vec_valid}, 32'h7);
    check("R4 nmi type", vec_type, 2);
    check("R4 nmi address", tgt_addr, 32'h8);
    boundary();
    check("R6 held level served once", {31'd0, int_take}, 0);

    // R6 new edge recognized on the serving edge
    nmi_in = 0; repeat (3) step();
    nmi_in = 1; repeat (3) step();
    nmi_in = 0; repeat (3) step();
    nmi_in = 1; repeat (2) step();
    boundary();
    check("R6 first service", {30'd0, int_take, int_nmi}, 32'h3);
    boundary();
    check("R6 re-armed service", {30'd0, int_take, int_nmi}, 32'h3);
    nmi_in = 0; repeat (3) step();

    // R5 priority, R10 flag, R8 masking, R9 acknowledge
    if_wr = 1; if_wdata = 1; intr_in = 1;
    step();
    if_wr = 0;
    step();
    check("R10 flag write", {31'd0, if_flag}, 1);
    nmi_in = 1; repeat (3) step();
    boundary();
    check("R5 nmi wins", {29'd0, int_take, int_nmi, ack_req}, 32'h6);
    check("R10 service clears flag", {31'd0, if_flag}, 0);
    nmi_in = 0;
    boundary();
    check("R8 masked request ignored", {31'd0, int_take}, 0);
    if_wr = 1; if_wdata = 1;
    step();
    if_wr = 0;
    boundary();
    check("R8 maskable take", {29'd0, int_take, int_nmi, ack_req}, 32'h5);
    check("R10 maskable clears flag", {31'd0, if_flag}, 0);
    if_wr = 1; if_wdata = 1;
    step();
    if_wr = 0;
    boundary();
    check("R9 no service while waiting", {31'd0, int_take}, 0);
    ack_valid = 1; ack_type = 8'h47;
    step();
    ack_valid = 0;
    check("R9 vector valid", {31'd0, vec_valid}, 1);
    check("R9 vector type", vec_type, 32'h47);
    check("R11 vector address", tgt_addr, slot(8'h47));
    step();
    check("R9 vector one cycle", {31'd0, vec_valid}, 0);
    intr_in = 0;
    step();

    // R8 request only in the boundary cycle
    intr_in = 1; instr_end = 1;
    step();
    check("R8 late request not taken", {31'd0, int_take}, 0);
    intr_in = 0; instr_end = 0;
    repeat (2) step();

    // R10 write in the same cycle as service
    intr_in = 1;
    step();
    instr_end = 1; if_wr = 1; if_wdata = 1;
    step();
    instr_end = 0; if_wr = 0; intr_in = 0;
    check("R10 service beats write", {30'd0, int_take, if_flag}, 32'h2);
    ack_valid = 1; ack_type = 8'hFF;
    step();
    ack_valid = 0;
    check("R11 top slot", tgt_addr, 32'h3FC);
    step();

    // R7 level held across reset end is never an edge
    rst_in = 1; nmi_in = 1;
    repeat (6) step();
    rst_in = 0;
    takes = 0;
    for (int i = 0; i < 30; i++) begin
      instr_end = 1;
      step();
      takes += int'(int_take);
    end
    instr_end = 0;
    check("R7 held nmi dropped", takes, 0);
    nmi_in = 0; repeat (3) step();
    nmi_in = 1; repeat (3) step();
    boundary();
    check("R7 later edge served", {30'd0, int_take, int_nmi}, 32'h3);
    nmi_in = 0; repeat (3) step();

    // R2 short pulse stretched
    rst_in = 1;
    step();
    rst_in = 0;
    held = int'(core_hold);
    for (int i = 0; i < 30; i++) begin
      step();
      held += int'(core_hold);
    end
    check("R2 stretched hold length", held, 12);
    repeat (4) step();

    // seeded random phase for R8 R9 R10
    void'($urandom(32'h5eed_1234));
    m_if = 0; m_iq = 0; m_wait = 0;
    for (int i = 0; i < 600; i++) begin
      ii = 1'($urandom % 2);
      ie = ($urandom % 3) == 0;
      iw = ($urandom % 5) == 0;
      wd = 1'($urandom % 2);
      av = m_wait && (($urandom % 3) == 0);
      at = 8'($urandom);
      intr_in = ii; instr_end = ie; if_wr = iw; if_wdata = wd;
      ack_valid = av; ack_type = at;
      step();
      exp_v = 0;
      exp_v[0] = ie && !m_wait && m_iq && m_if;
      exp_v[1] = exp_v[0];
      exp_v[2] = m_wait && av;
      exp_v[3] = exp_v[0] ? 1'b0 : (iw ? wd : m_if);
      if (exp_v[2]) exp_v[31:4] = {slot(at)[19:0], at};
      act_v = {tgt_addr, vec_type, if_flag, vec_valid, ack_req, int_take};
      if (!exp_v[2]) act_v[31:4] = 0;
      if (int_nmi) act_v = ~act_v;
      check("R8 R9 R10 random", act_v, exp_v);
      m_if   = exp_v[3];
      m_wait = exp_v[0] ? 1'b1 : (exp_v[2] ? 1'b0 : m_wait);
      m_iq   = ii;
    end
    intr_in = 0; instr_end = 0; if_wr = 0; ack_valid = 0;
    step();
    report();
  end

endmodule